// File: doc/BRIEF.md
# Bank Row Timing and Auto-Precharge Scheduler

This block follows the row state of one DRAM bank from the controller side and counts every interval in clock cycles. Four command strobes come in: activate, write, write with automatic precharge, and explicit precharge. A fifth strobe reports an activate issued to some other bank. From these strobes and a set of timing limits held in registers, the block drives three ready flags. Each flag tells the command scheduler whether an activate, a write or a precharge may go out in the current cycle. The block decides the cycle in which the internal precharge of an auto-precharge write begins, and it keeps two sticky error bits: one for illegal commands and one for a row left open too long.

All timing limits come in on plain configuration pins as cycle counts. They are captured only while the bank is idle, so a change made while a row is open takes effect at the next activate. There is no data stream through the block. Every pin is a plain level or a single-cycle strobe, and the block never back-pressures its driver. A command that arrives while its ready flag is low is dropped and recorded.

"Window k after a command" means the k-th clock cycle after the cycle in which the strobe was sampled high. The row age is the number of windows since the last accepted activate.

Top module: `bank_sched`

## Requirements
- R1: After reset, act_ready is 1, while wr_ready, pre_ready, row_open, ap_start, err_cmd and err_ras are all 0.
- R2: act_ready is 1 only when three conditions hold: the bank is idle, the row age is at least cfg_trc, and at least cfg_trrd windows have passed since the last peer_act pulse.
- R3: After an activate, wr_ready first rises in the window where the row age equals cfg_trcd_rd minus (cfg_wl + 1). If that difference is not positive, the limit is zero.
- R4: A write burst is four beats, which is two clock cycles. After an accepted write, wr_ready is 0 in the next window and may be 1 again two windows after the write.
- R5: pre_ready is 1 only when the row is open, the row age is at least cfg_tras, no auto-precharge is pending, and at least cfg_wl + 2 + cfg_twr windows have passed since the last accepted write.
- R6: After an accepted auto-precharge write, ap_start pulses for one cycle in window cfg_wl + 2 + cfg_twr. This holds when the row age in that window is at least cfg_tras. While the auto-precharge is pending, wr_ready and pre_ready stay 0.
- R7: If the row age in that nominal window is below cfg_tras, ap_start instead pulses in the window where the row age equals cfg_tras + 1.
- R8: After an accepted explicit precharge, or an ap_start pulse, row_open is 0 from the next window. The bank is idle cfg_trp windows after the precharge.
- R9: err_ras is set, and stays set until reset, one window after the row age of an open row first exceeds 8 times cfg_trefi.
- R10: A command whose ready flag is 0 is ignored and sets err_cmd, which stays set until reset. Two cases count as illegal in the same way: more than one strobe in a cycle, and cmd_act together with peer_act.
- R11: The cfg_* inputs are sampled only while the bank is idle. A change made while a row is open has no effect on that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act | input | 1 | Activate strobe for this bank |
| cmd_wr | input | 1 | Write strobe without auto-precharge |
| cmd_wr_ap | input | 1 | Write strobe with auto-precharge |
| cmd_pre | input | 1 | Explicit precharge strobe |
| peer_act | input | 1 | An activate went to another bank this cycle |
| cfg_trc | input | TW | Minimum activate-to-activate, same bank |
| cfg_tras | input | TW | Minimum row-active time |
| cfg_trrd | input | TW | Minimum spacing after another bank's activate |
| cfg_trcd_rd | input | TW | Activate-to-read delay; the write delay is derived from it |
| cfg_wl | input | TW | Write latency |
| cfg_twr | input | TW | Write recovery after the last beat |
| cfg_trp | input | TW | Precharge-to-idle time |
| cfg_trefi | input | RW | Refresh interval; a row may stay open up to 8 times this |
| act_ready | output | 1 | An activate is legal this cycle |
| wr_ready | output | 1 | A write is legal this cycle |
| pre_ready | output | 1 | An explicit precharge is legal this cycle |
| ap_start | output | 1 | The internal auto-precharge begins this cycle |
| row_open | output | 1 | A row is active |
| err_cmd | output | 1 | Sticky: an illegal command was seen |
| err_ras | output | 1 | Sticky: the row-open limit was exceeded |

## Verification
The assertions assume the driver raises at most one strobe per cycle, and raises it only after looking at the matching ready flag. The one exception is a single deliberate illegal write, which the sticky-error property must observe. They also assume that cfg_trp and cfg_trc stay positive, so that a closed row cannot count as ready in the same window it closes. The stimulus sets every strobe on the falling edge, keeps it high for exactly one cycle, and picks each issue window from the requirement arithmetic, so every command except that deliberate one meets its ready flag.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;
  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_state_e;
endpackage

// File: rtl/bank_age_ctr.sv
// Saturating count of cycles since the last clear; resets to its maximum.
module bank_age_ctr #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= MAXV;
    else if (clr)       q <= W'(1);
    else if (q != MAXV) q <= q + W'(1);
  end
endmodule

// File: rtl/bank_cfg_hold.sv
// Captures timing limits while idle and derives the write row-to-column delay.
module bank_cfg_hold #(
  parameter int TW = 6,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] in_trc,
  input  logic [TW-1:0] in_tras,
  input  logic [TW-1:0] in_trrd,
  input  logic [TW-1:0] in_trcd_rd,
  input  logic [TW-1:0] in_wl,
  input  logic [TW-1:0] in_twr,
  input  logic [TW-1:0] in_trp,
  input  logic [RW-1:0] in_trefi,
  output logic [TW-1:0] trc,
  output logic [TW-1:0] tras,
  output logic [TW-1:0] trrd,
  output logic [TW-1:0] trcd_wr,
  output logic [TW-1:0] wl,
  output logic [TW-1:0] twr,
  output logic [TW-1:0] trp,
  output logic [RW-1:0] trefi
);
  logic [TW-1:0] trcd_rd;
  logic [TW:0]   wr_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc <= '0; tras <= '0; trrd <= '0; trcd_rd <= '0;
      wl <= '0; twr <= '0; trp <= '0; trefi <= '0;
    end else if (load) begin
      trc <= in_trc; tras <= in_tras; trrd <= in_trrd; trcd_rd <= in_trcd_rd;
      wl <= in_wl; twr <= in_twr; trp <= in_trp; trefi <= in_trefi;
    end
  end

  always_comb begin
    wr_gap  = {1'b0, wl} + (TW+1)'(1);
    trcd_wr = ({1'b0, trcd_rd} > wr_gap) ? TW'({1'b0, trcd_rd} - wr_gap) : '0;
  end
endmodule

// File: rtl/bank_wr_track.sv
// Burst spacing, write recovery and auto-precharge start decision.
module bank_wr_track #(
  parameter int TW        = 6,
  parameter int AW        = 14,
  parameter int BURST_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          ap_go,
  input  logic [TW-1:0] wl,
  input  logic [TW-1:0] twr,
  input  logic [TW-1:0] tras,
  input  logic [AW-1:0] age,
  output logic          burst_idle,
  output logic          rec_done,
  output logic          ap_pending,
  output logic          ap_start
);
  localparam int BW = $clog2(BURST_CYC + 1);
  localparam int RC = TW + 2;

  logic [BW-1:0] burst_cnt;
  logic [RC-1:0] rec_cnt;
  logic [RC-1:0] rec_load;
  logic          ap_late;
  logic [AW-1:0] tras_w;
  logic          at_nominal;

  assign tras_w     = {{(AW-TW){1'b0}}, tras};
  assign rec_load   = {2'b00, wl} + RC'(BURST_CYC) + {2'b00, twr} - RC'(1);
  assign burst_idle = (burst_cnt == '0);
  assign rec_done   = (rec_cnt == '0);
  assign at_nominal = ap_pending && rec_done;
  assign ap_start   = at_nominal && (ap_late ? (age > tras_w) : (age >= tras_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_cnt <= '0;
      rec_cnt   <= '0;
    end else if (wr_go) begin
      burst_cnt <= BW'(BURST_CYC - 1);
      rec_cnt   <= rec_load;
    end else begin
      if (!burst_idle) burst_cnt <= burst_cnt - BW'(1);
      if (!rec_done)   rec_cnt   <= rec_cnt - RC'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_pending <= 1'b0;
      ap_late    <= 1'b0;
    end else if (ap_start) begin
      ap_pending <= 1'b0;
      ap_late    <= 1'b0;
    end else begin
      if (wr_go && ap_go)                  ap_pending <= 1'b1;
      if (at_nominal && (age < tras_w))    ap_late    <= 1'b1;
    end
  end
endmodule

// File: rtl/bank_sched.sv
module bank_sched #(
  parameter int TW            = 6,
  parameter int RW            = 10,
  parameter int BEATS         = 4,
  parameter int BEATS_PER_CLK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_act,
  input  logic          cmd_wr,
  input  logic          cmd_wr_ap,
  input  logic          cmd_pre,
  input  logic          peer_act,
  input  logic [TW-1:0] cfg_trc,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_trrd,
  input  logic [TW-1:0] cfg_trcd_rd,
  input  logic [TW-1:0] cfg_wl,
  input  logic [TW-1:0] cfg_twr,
  input  logic [TW-1:0] cfg_trp,
  input  logic [RW-1:0] cfg_trefi,
  output logic          act_ready,
  output logic          wr_ready,
  output logic          pre_ready,
  output logic          ap_start,
  output logic          row_open,
  output logic          err_cmd,
  output logic          err_ras
);
  import bank_sched_pkg::*;

  localparam int BURST_CYC = BEATS / BEATS_PER_CLK;
  localparam int AW        = RW + 4;

  bank_state_e   state;
  logic [TW-1:0] pcnt;
  logic [TW-1:0] trc, tras, trrd, trcd_wr, wl, twr, trp;
  logic [RW-1:0] trefi;
  logic [AW-1:0] row_age, peer_age;
  logic          burst_idle, rec_done, ap_pending;
  logic          bad, act_ok, wr_ok, pre_ok, close_now;
  logic [2:0]    n_cmd;

  bank_cfg_hold #(.TW(TW), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(state == BK_IDLE),
    .in_trc(cfg_trc), .in_tras(cfg_tras), .in_trrd(cfg_trrd),
    .in_trcd_rd(cfg_trcd_rd), .in_wl(cfg_wl), .in_twr(cfg_twr),
    .in_trp(cfg_trp), .in_trefi(cfg_trefi),
    .trc(trc), .tras(tras), .trrd(trrd), .trcd_wr(trcd_wr),
    .wl(wl), .twr(twr), .trp(trp), .trefi(trefi)
  );

  // One age counter for this bank's activates, one for the peers'.
  for (genvar g = 0; g < 2; g++) begin : g_age
    if (g == 0) begin : g_row
      bank_age_ctr #(.W(AW)) u_ctr (.clk(clk), .rst_n(rst_n), .clr(act_ok), .q(row_age));
    end else begin : g_peer
      bank_age_ctr #(.W(AW)) u_ctr (.clk(clk), .rst_n(rst_n), .clr(peer_act), .q(peer_age));
    end
  end

  bank_wr_track #(.TW(TW), .AW(AW), .BURST_CYC(BURST_CYC)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_ok), .ap_go(cmd_wr_ap),
    .wl(wl), .twr(twr), .tras(tras), .age(row_age),
    .burst_idle(burst_idle), .rec_done(rec_done),
    .ap_pending(ap_pending), .ap_start(ap_start)
  );

  // Ready flags come from registers only.
  assign row_open  = (state == BK_OPEN);
  assign act_ready = (state == BK_IDLE) && (row_age >= AW'(trc)) && (peer_age >= AW'(trrd));
  assign wr_ready  = row_open && (row_age >= AW'(trcd_wr)) && burst_idle && !ap_pending;
  assign pre_ready = row_open && (row_age >= AW'(tras)) && rec_done && !ap_pending;

  always_comb begin
    n_cmd     = 3'(cmd_act) + 3'(cmd_wr) + 3'(cmd_wr_ap) + 3'(cmd_pre);
    bad       = (n_cmd > 3'd1) || (cmd_act && peer_act) ||
                (cmd_act && !act_ready) || ((cmd_wr || cmd_wr_ap) && !wr_ready) ||
                (cmd_pre && !pre_ready);
    act_ok    = cmd_act && !bad;
    wr_ok     = (cmd_wr || cmd_wr_ap) && !bad;
    pre_ok    = cmd_pre && !bad;
    close_now = pre_ok || ap_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      pcnt  <= '0;
    end else begin
      unique case (state)
        BK_IDLE: if (act_ok) state <= BK_OPEN;
        BK_OPEN: if (close_now) begin
          if (trp <= TW'(1)) state <= BK_IDLE;
          else begin
            state <= BK_CLOSING;
            pcnt  <= trp - TW'(1);
          end
        end
        BK_CLOSING: begin
          if (pcnt <= TW'(1)) state <= BK_IDLE;
          pcnt <= pcnt - TW'(1);
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cmd <= 1'b0;
      err_ras <= 1'b0;
    end else begin
      if (bad) err_cmd <= 1'b1;
      if (row_open && (row_age > {1'b0, trefi, 3'b000})) err_ras <= 1'b1;
    end
  end
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_act,
  input logic cmd_wr,
  input logic cmd_wr_ap,
  input logic cmd_pre,
  input logic act_ready,
  input logic wr_ready,
  input logic pre_ready,
  input logic ap_start,
  input logic row_open,
  input logic err_cmd
);
  assert_act_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_ready |-> !row_open);

  assert_burst_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_ready && !cmd_act && !cmd_pre && !cmd_wr_ap) |=> !wr_ready);

  assert_ap_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |-> (!wr_ready && !pre_ready && row_open));

  assert_ap_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |=> !row_open);

  assert_bad_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && !pre_ready) |=> err_cmd);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |=> err_cmd);
endmodule

bind bank_sched bank_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_wr(cmd_wr),
  .cmd_wr_ap(cmd_wr_ap), .cmd_pre(cmd_pre), .act_ready(act_ready),
  .wr_ready(wr_ready), .pre_ready(pre_ready), .ap_start(ap_start),
  .row_open(row_open), .err_cmd(err_cmd)
);

// File: tb/bank_sched_test.sv
module bank_sched_test;
  localparam int TW = 6;
  localparam int RW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_act = 0, cmd_wr = 0, cmd_wr_ap = 0, cmd_pre = 0, peer_act = 0;
  logic [TW-1:0] cfg_trc = 10, cfg_tras = 7, cfg_trrd = 2, cfg_trcd_rd = 6;
  logic [TW-1:0] cfg_wl = 2, cfg_twr = 2, cfg_trp = 3;
  logic [RW-1:0] cfg_trefi = 5;
  logic act_ready, wr_ready, pre_ready, ap_start, row_open, err_cmd, err_ras;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_sched #(.TW(TW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_wr(cmd_wr),
    .cmd_wr_ap(cmd_wr_ap), .cmd_pre(cmd_pre), .peer_act(peer_act),
    .cfg_trc(cfg_trc), .cfg_tras(cfg_tras), .cfg_trrd(cfg_trrd),
    .cfg_trcd_rd(cfg_trcd_rd), .cfg_wl(cfg_wl), .cfg_twr(cfg_twr),
    .cfg_trp(cfg_trp), .cfg_trefi(cfg_trefi),
    .act_ready(act_ready), .wr_ready(wr_ready), .pre_ready(pre_ready),
    .ap_start(ap_start), .row_open(row_open), .err_cmd(err_cmd), .err_ras(err_ras)
  );

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s at window %0d: got %0d expected %0d", req, cyc, actual, expected);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // kind: 0 act, 1 write, 2 write+auto-precharge, 3 precharge, 4 peer activate
  task automatic issue(input int kind, output int w);
    w = cyc;
    case (kind)
      0: cmd_act = 1;
      1: cmd_wr = 1;
      2: cmd_wr_ap = 1;
      3: cmd_pre = 1;
      default: peer_act = 1;
    endcase
    @(negedge clk);
    cmd_act = 0; cmd_wr = 0; cmd_wr_ap = 0; cmd_pre = 0; peer_act = 0;
  endtask

  // Scoreboard monitor: every ap_start pulse must match the next expected window.
  always @(negedge clk) begin
    if (rst_n && ap_start) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6/R7 unexpected ap_start at window %0d: got 1 expected 0", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R6/R7 ap_start window: got %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a, b, c, d, g, h, e, w, x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 act_ready", act_ready, 1);
    check("R1 wr_ready", wr_ready, 0);
    check("R1 pre_ready", pre_ready, 0);
    check("R1 row_open", row_open, 0);
    check("R1 err_cmd", int'(err_cmd) + int'(err_ras) + int'(ap_start), 0);
    @(negedge clk);

    // R3 derived write delay (6 - 3 = 3), R6 nominal auto-precharge, R8 close
    issue(0, a);
    wait_to(a + 2); check("R3 wr_ready early", wr_ready, 0);
    wait_to(a + 3); check("R3 wr_ready on time", wr_ready, 1);
    issue(2, w);
    exp_q.push_back(w + 6);
    check("R6 wr_ready while pending", wr_ready, 0);
    check("R5 pre_ready while pending", pre_ready, 0);
    wait_to(a + 9);  check("R8 row_open at ap", row_open, 1);
    wait_to(a + 10); check("R8 row_open after ap", row_open, 0);
    wait_to(a + 11); check("R8 act_ready before trp", act_ready, 0);
    wait_to(a + 12); check("R8 act_ready after trp", act_ready, 1);

    // R7 delayed auto-precharge: tras 14, nominal age 9 -> start at age 15
    cfg_tras = 14;
    issue(0, b);
    wait_to(b + 3); issue(2, w);
    exp_q.push_back(b + 15);
    wait_to(b + 14); check("R7 row still open", row_open, 1);
    wait_to(b + 18); check("R7 idle after delayed ap", act_ready, 1);

    // R6 boundary: nominal age equals tras
    cfg_tras = 9;
    issue(0, c);
    wait_to(c + 3); issue(2, w);
    exp_q.push_back(c + 9);
    wait_to(c + 12); check("R6 boundary close", act_ready, 1);

    // R4 burst spacing, R5 write recovery, R11 config held while open
    issue(0, d);
    wait_to(d + 3); issue(1, w);
    check("R4 wr_ready after write", wr_ready, 0);
    cfg_tras = 30;
    wait_to(d + 5); check("R4 wr_ready after burst", wr_ready, 1);
    issue(1, w);
    wait_to(d + 10); check("R5 pre_ready in recovery", pre_ready, 0);
    wait_to(d + 11); check("R11 pre_ready uses held tras", pre_ready, 1);
    issue(3, w);
    check("R8 row_open after pre", row_open, 0);
    wait_to(d + 13); check("R8 act_ready before trp", act_ready, 0);
    wait_to(d + 14); check("R8 act_ready at trp", act_ready, 1);
    cfg_tras = 9;

    // R2 same-bank activate spacing with trc 20
    cfg_trc = 20;
    issue(0, g);
    wait_to(g + 9); issue(3, w);
    wait_to(g + 19); check("R2 act_ready before trc", act_ready, 0);
    wait_to(g + 20); check("R2 act_ready at trc", act_ready, 1);

    // R2 peer activate spacing with trrd 2
    issue(4, h);
    check("R2 act_ready after peer", act_ready, 0);
    wait_to(h + 2); check("R2 act_ready after trrd", act_ready, 1);

    // R9 row open beyond 8 * trefi = 40
    issue(0, e);
    wait_to(e + 41); check("R9 err_ras not yet", err_ras, 0);
    wait_to(e + 42); check("R9 err_ras set", err_ras, 1);
    check("R9 row still open", row_open, 1);
    issue(3, w);
    wait_to(e + 45); check("R9 err_ras sticky", err_ras, 1);

    // R10 illegal write while idle is dropped and flagged
    check("R10 err_cmd clean", err_cmd, 0);
    issue(1, x);
    check("R10 err_cmd set", err_cmd, 1);
    check("R10 row stays closed", row_open, 0);
    check("R10 wr_ready stays low", wr_ready, 0);
    @(negedge clk);
    check("R10 err_cmd sticky", err_cmd, 1);

    check("R6 all expected ap_start seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule